// File: doc/BRIEF.md
# Buffer descriptor ring sequencer

This block keeps one table of two-word buffer descriptors (a status/length word and a buffer address word) and walks it as two rings: a transmit ring made of the first N entries and a receive ring made of the entries from N up to the end of the table. N is programmed through a split register. Software hands a descriptor to the hardware by setting its ownership bit (ready for transmit, empty for receive). The block offers owned transmit descriptors to the frame datapath, takes back completion results, and fills receive descriptors as frames are reported. Each ring returns to its first entry after servicing a descriptor that carries the wrap flag, so ring lengths are set by software and are not fixed.

Both datapath links are valid/ready streams. A transmit request, once valid, stays valid with stable fields until ready is seen; the completion stream is accepted only while the block waits for a result. The receive report stream is accepted in any cycle the receive ring is enabled; the block never stalls it, and a report that finds no empty descriptor is dropped with a busy interrupt. Completion events set bits in an interrupt source register whose bits clear when written with one; an enable mask gates the interrupt output.

Top module: `bdr_ring_seq`

## Requirements
- R1: After reset both enables, the interrupt source, the interrupt mask and the interrupt output are zero, the split register reads DESC_MAX/2, and no transmit request is valid.
- R2: A write to the split register (offset 0x10) with a value above DESC_MAX stores DESC_MAX; smaller values are stored as written.
- R3: Descriptor i is reached at byte offset 0x400 + 8*i: its status word at +0 and its buffer address word at +4, both readable and writable.
- R4: With transmit enabled (control register offset 0x00, bit 1), a descriptor at the transmit pointer with bit 15 set is offered on the request stream with its address word, length from status bits 31:16, pad flag from bit 12 and CRC flag from bit 11.
- R5: When the descriptor at the transmit pointer has bit 15 clear, no request is offered and the pointer stays there; later descriptors are not taken.
- R6: A transmit completion writes the 9-bit result into status bits 8:0 (bit 0 carrier lost, 1 defer, 2 late collision, 3 retry limit, 7:4 retry count, 8 underrun), clears bit 15 and keeps all other bits; if bit 14 was set it raises interrupt bit 1 when any of result bits 0, 2, 3 or 8 is set, else interrupt bit 0.
- R7: After servicing a descriptor with bit 13 set, or the last entry of its ring, the transmit pointer returns to 0 and the receive pointer returns to N.
- R8: With receive enabled (control bit 0), a report landing on a descriptor with bit 15 set writes the length into bits 31:16, the 9-bit result into bits 8:0 and clears bit 15, keeping bits 14:9; if bit 14 was set it raises interrupt bit 6 when result bit 8 is set, else bit 3 when any of result bits 7:0 is set, else bit 2.
- R9: A report that finds the current receive descriptor with bit 15 clear, or no receive ring (N equal to DESC_MAX), changes no descriptor, leaves the pointer in place and raises interrupt bit 4.
- R10: With receive disabled the report stream is not ready and with transmit disabled no request is offered; disabling a ring returns its pointer to its first entry.
- R11: Writing ones to the interrupt source register (offset 0x04) clears those bits; the interrupt output is high exactly when a source bit is set whose bit in the mask register (offset 0x08) is set.
- R12: A valid transmit request that is not accepted stays valid with the same address and length in the next cycle while transmit stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register/table write strobe |
| bus_addr | input | BUS_AW | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Masked interrupt request |
| tx_req_valid | output | 1 | Transmit descriptor offered |
| tx_req_ready | input | 1 | Datapath accepts the offered descriptor |
| tx_req_addr | output | 32 | Buffer address of the offered frame |
| tx_req_len | output | 16 | Frame length in bytes |
| tx_req_pad | output | 1 | Pad short frame |
| tx_req_crc | output | 1 | Append CRC |
| tx_done_valid | input | 1 | Transmit result present |
| tx_done_ready | output | 1 | Block waits for a transmit result |
| tx_done_status | input | 9 | Transmit result flags and retry count |
| rx_frm_valid | input | 1 | Received frame report present |
| rx_frm_ready | output | 1 | Report stream accepted this cycle |
| rx_frm_len | input | 16 | Received length including CRC |
| rx_frm_status | input | 9 | Receive error flags (7:0) and control-frame flag (8) |
| rx_buf_addr | output | 32 | Buffer address of the current receive descriptor |

## Verification
The assertions take for granted that the split register is rewritten only while both rings are disabled, that software leaves a descriptor alone while the hardware owns and is servicing it, and that transmit results arrive only after a request has been accepted. The stimulus keeps to this by clearing the control register before every change of split, by touching descriptors only while the matching ring is stalled or disabled, and by driving a result only in the cycle after the request handshake. Under those conditions the ring pointers stay inside their rings and the receive busy report follows every report that finds no empty descriptor.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int ST_OWN  = 15;
  localparam int ST_IRQ  = 14;
  localparam int ST_WRAP = 13;
  localparam int ST_PAD  = 12;
  localparam int ST_CRC  = 11;

  localparam int IRQ_W    = 7;
  localparam int IRQ_TXF  = 0;
  localparam int IRQ_TXE  = 1;
  localparam int IRQ_RXF  = 2;
  localparam int IRQ_RXE  = 3;
  localparam int IRQ_BUSY = 4;
  localparam int IRQ_RXC  = 6;

  localparam int RES_W = 9;
  localparam logic [RES_W-1:0] TX_ERR_BITS = 9'h10D;

  localparam int REG_CTRL  = 'h00;
  localparam int REG_ISRC  = 'h04;
  localparam int REG_IMSK  = 'h08;
  localparam int REG_SPLIT = 'h10;
  localparam int TBL_BASE  = 'h400;

  typedef enum logic [1:0] {TXS_POLL, TXS_OFFER, TXS_WAIT} tx_state_e;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic        pad;
    logic        crc;
  } tx_job_t;
endpackage

// File: rtl/bdr_regs.sv
module bdr_regs
  import bdr_pkg::*;
#(
  parameter int DESC_MAX = 128,
  parameter int CNT_W    = 8,
  parameter int BUS_AW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [IRQ_W-1:0]  irq_set,
  output logic              tx_en,
  output logic              rx_en,
  output logic [CNT_W-1:0]  split,
  output logic [IRQ_W-1:0]  irq_src,
  output logic [IRQ_W-1:0]  irq_mask,
  output logic              irq_o,
  output logic [31:0]       rdata
);
  localparam logic [CNT_W-1:0] SPLIT_RST = CNT_W'(DESC_MAX / 2);
  localparam logic [CNT_W-1:0] SPLIT_TOP = CNT_W'(DESC_MAX);

  logic            hit_ctrl, hit_isrc, hit_imsk, hit_split;
  logic [IRQ_W-1:0] clr_bits;

  assign hit_ctrl  = addr == BUS_AW'(REG_CTRL);
  assign hit_isrc  = addr == BUS_AW'(REG_ISRC);
  assign hit_imsk  = addr == BUS_AW'(REG_IMSK);
  assign hit_split = addr == BUS_AW'(REG_SPLIT);
  assign clr_bits  = (wr_en && hit_isrc) ? wdata[IRQ_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      split    <= SPLIT_RST;
      irq_src  <= '0;
      irq_mask <= '0;
    end else begin
      if (wr_en && hit_ctrl) begin
        tx_en <= wdata[1];
        rx_en <= wdata[0];
      end
      if (wr_en && hit_imsk) irq_mask <= wdata[IRQ_W-1:0];
      if (wr_en && hit_split) begin
        if (wdata > 32'(DESC_MAX)) split <= SPLIT_TOP;
        else                       split <= wdata[CNT_W-1:0];
      end
      irq_src <= (irq_src & ~clr_bits) | irq_set;
    end
  end

  assign irq_o = |(irq_src & irq_mask);

  always_comb begin
    rdata = '0;
    if (hit_ctrl)  rdata = {30'd0, tx_en, rx_en};
    if (hit_isrc)  rdata = {{(32-IRQ_W){1'b0}}, irq_src};
    if (hit_imsk)  rdata = {{(32-IRQ_W){1'b0}}, irq_mask};
    if (hit_split) rdata = {{(32-CNT_W){1'b0}}, split};
  end
endmodule

// File: rtl/bdr_table.sv
module bdr_table #(
  parameter int DESC_MAX = 128,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_idx,
  input  logic             bus_word,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             tx_we,
  input  logic [CNT_W-1:0] tx_idx,
  input  logic [31:0]      tx_wdata,
  output logic [31:0]      tx_stat,
  output logic [31:0]      tx_addr,
  input  logic             rx_we,
  input  logic [CNT_W-1:0] rx_idx,
  input  logic [31:0]      rx_wdata,
  output logic [31:0]      rx_stat,
  output logic [31:0]      rx_addr
);
  localparam int IDX_W = $clog2(DESC_MAX);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DESC_MAX);

  logic [31:0] stat_v [DESC_MAX];
  logic [31:0] addr_v [DESC_MAX];

  for (genvar e = 0; e < DESC_MAX; e++) begin : g_ent
    logic [31:0] stat_r, addr_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat_r <= '0;
        addr_r <= '0;
      end else begin
        if (rx_we && rx_idx == CNT_W'(e))      stat_r <= rx_wdata;
        else if (tx_we && tx_idx == CNT_W'(e)) stat_r <= tx_wdata;
        else if (bus_we && !bus_word && bus_idx == CNT_W'(e)) stat_r <= bus_wdata;
        if (bus_we && bus_word && bus_idx == CNT_W'(e)) addr_r <= bus_wdata;
      end
    end
    assign stat_v[e] = stat_r;
    assign addr_v[e] = addr_r;
  end

  always_comb begin
    bus_rdata = '0;
    tx_stat   = '0;
    tx_addr   = '0;
    rx_stat   = '0;
    rx_addr   = '0;
    if (bus_idx < LIMIT)
      bus_rdata = bus_word ? addr_v[bus_idx[IDX_W-1:0]] : stat_v[bus_idx[IDX_W-1:0]];
    if (tx_idx < LIMIT) begin
      tx_stat = stat_v[tx_idx[IDX_W-1:0]];
      tx_addr = addr_v[tx_idx[IDX_W-1:0]];
    end
    if (rx_idx < LIMIT) begin
      rx_stat = stat_v[rx_idx[IDX_W-1:0]];
      rx_addr = addr_v[rx_idx[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/bdr_tx_walker.sv
module bdr_tx_walker
  import bdr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] split,
  input  logic [31:0]      stat,
  input  logic [31:0]      baddr,
  output logic [CNT_W-1:0] ptr,
  output logic             req_valid,
  input  logic             req_ready,
  output tx_job_t          job,
  input  logic             done_valid,
  output logic             done_ready,
  input  logic [RES_W-1:0] done_status,
  output logic             wb_en,
  output logic [31:0]      wb_data,
  output logic [IRQ_W-1:0] irq_set
);
  tx_state_e        state;
  logic             live;
  logic [CNT_W-1:0] ptr_nxt;

  assign live    = en && (split != '0);
  assign ptr_nxt = (stat[ST_WRAP] || ptr == split - 1'b1) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TXS_POLL;
      ptr   <= '0;
      job   <= '0;
    end else if (!live) begin
      state <= TXS_POLL;
      ptr   <= '0;
    end else begin
      case (state)
        TXS_POLL: if (stat[ST_OWN]) begin
          job.addr <= baddr;
          job.len  <= stat[31:16];
          job.pad  <= stat[ST_PAD];
          job.crc  <= stat[ST_CRC];
          state    <= TXS_OFFER;
        end
        TXS_OFFER: if (req_ready) state <= TXS_WAIT;
        TXS_WAIT: if (done_valid) begin
          ptr   <= ptr_nxt;
          state <= TXS_POLL;
        end
        default: state <= TXS_POLL;
      endcase
    end
  end

  assign req_valid  = live && state == TXS_OFFER;
  assign done_ready = live && state == TXS_WAIT;
  assign wb_en      = done_valid && done_ready;
  assign wb_data    = {stat[31:16], 1'b0, stat[14:9], done_status};

  always_comb begin
    irq_set = '0;
    if (wb_en && stat[ST_IRQ]) begin
      if (|(done_status & TX_ERR_BITS)) irq_set[IRQ_TXE] = 1'b1;
      else                              irq_set[IRQ_TXF] = 1'b1;
    end
  end
endmodule

// File: rtl/bdr_rx_walker.sv
module bdr_rx_walker
  import bdr_pkg::*;
#(
  parameter int DESC_MAX = 128,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] split,
  input  logic [31:0]      stat,
  output logic [CNT_W-1:0] ptr,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic [15:0]      frm_len,
  input  logic [RES_W-1:0] frm_status,
  output logic             wb_en,
  output logic [31:0]      wb_data,
  output logic [IRQ_W-1:0] irq_set
);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(DESC_MAX - 1);
  localparam logic [CNT_W-1:0] PTR_RST   = CNT_W'(DESC_MAX / 2);
  localparam logic [CNT_W-1:0] SPLIT_TOP = CNT_W'(DESC_MAX);

  logic             take, slot_ok, land;
  logic [CNT_W-1:0] ptr_nxt;

  assign frm_ready = en;
  assign take      = frm_valid && frm_ready;
  assign slot_ok   = (split < SPLIT_TOP) && stat[ST_OWN];
  assign land      = take && slot_ok;
  assign ptr_nxt   = (stat[ST_WRAP] || ptr == LAST) ? split : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= PTR_RST;
    else if (!en)  ptr <= split;
    else if (land) ptr <= ptr_nxt;
  end

  assign wb_en   = land;
  assign wb_data = {frm_len, 1'b0, stat[14:9], frm_status};

  always_comb begin
    irq_set = '0;
    if (take && !slot_ok) irq_set[IRQ_BUSY] = 1'b1;
    if (land && stat[ST_IRQ]) begin
      if (frm_status[8])         irq_set[IRQ_RXC] = 1'b1;
      else if (|frm_status[7:0]) irq_set[IRQ_RXE] = 1'b1;
      else                       irq_set[IRQ_RXF] = 1'b1;
    end
  end
endmodule

// File: rtl/bdr_ring_seq.sv
module bdr_ring_seq
  import bdr_pkg::*;
#(
  parameter int DESC_MAX = 128,
  parameter int BUS_AW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              tx_req_valid,
  input  logic              tx_req_ready,
  output logic [31:0]       tx_req_addr,
  output logic [15:0]       tx_req_len,
  output logic              tx_req_pad,
  output logic              tx_req_crc,
  input  logic              tx_done_valid,
  output logic              tx_done_ready,
  input  logic [8:0]        tx_done_status,
  input  logic              rx_frm_valid,
  output logic              rx_frm_ready,
  input  logic [15:0]       rx_frm_len,
  input  logic [8:0]        rx_frm_status,
  output logic [31:0]       rx_buf_addr
);
  localparam int IDX_W = $clog2(DESC_MAX);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [BUS_AW-1:0] TBL_A    = BUS_AW'(TBL_BASE);
  localparam logic [BUS_AW:0]   TBL_SPAN = (BUS_AW+1)'(DESC_MAX * 8);

  logic              tx_en, rx_en;
  logic [CNT_W-1:0]  split_q, tx_ptr, rx_ptr, tbl_idx;
  logic [IRQ_W-1:0]  irq_src, irq_mask, tx_irq, rx_irq;
  logic [BUS_AW-1:0] tbl_off;
  logic              tbl_hit;
  logic [31:0]       reg_rdata, tbl_rdata;
  logic [31:0]       tx_stat, tx_baddr, rx_stat, tx_wb_data, rx_wb_data;
  logic              tx_wb_en, rx_wb_en;
  tx_job_t           job;

  assign tbl_off = bus_addr - TBL_A;
  assign tbl_hit = (bus_addr >= TBL_A) && ({1'b0, tbl_off} < TBL_SPAN);
  assign tbl_idx = {1'b0, tbl_off[IDX_W+2:3]};

  bdr_regs #(.DESC_MAX(DESC_MAX), .CNT_W(CNT_W), .BUS_AW(BUS_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en && !tbl_hit), .addr(bus_addr),
    .wdata(bus_wdata), .irq_set(tx_irq | rx_irq), .tx_en(tx_en), .rx_en(rx_en),
    .split(split_q), .irq_src(irq_src), .irq_mask(irq_mask), .irq_o(irq_o),
    .rdata(reg_rdata)
  );

  bdr_table #(.DESC_MAX(DESC_MAX), .CNT_W(CNT_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_wr_en && tbl_hit), .bus_idx(tbl_idx), .bus_word(tbl_off[2]),
    .bus_wdata(bus_wdata), .bus_rdata(tbl_rdata),
    .tx_we(tx_wb_en), .tx_idx(tx_ptr), .tx_wdata(tx_wb_data),
    .tx_stat(tx_stat), .tx_addr(tx_baddr),
    .rx_we(rx_wb_en), .rx_idx(rx_ptr), .rx_wdata(rx_wb_data),
    .rx_stat(rx_stat), .rx_addr(rx_buf_addr)
  );

  bdr_tx_walker #(.CNT_W(CNT_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .split(split_q), .stat(tx_stat),
    .baddr(tx_baddr), .ptr(tx_ptr), .req_valid(tx_req_valid),
    .req_ready(tx_req_ready), .job(job), .done_valid(tx_done_valid),
    .done_ready(tx_done_ready), .done_status(tx_done_status),
    .wb_en(tx_wb_en), .wb_data(tx_wb_data), .irq_set(tx_irq)
  );

  bdr_rx_walker #(.DESC_MAX(DESC_MAX), .CNT_W(CNT_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .split(split_q), .stat(rx_stat),
    .ptr(rx_ptr), .frm_valid(rx_frm_valid), .frm_ready(rx_frm_ready),
    .frm_len(rx_frm_len), .frm_status(rx_frm_status),
    .wb_en(rx_wb_en), .wb_data(rx_wb_data), .irq_set(rx_irq)
  );

  assign tx_req_addr = job.addr;
  assign tx_req_len  = job.len;
  assign tx_req_pad  = job.pad;
  assign tx_req_crc  = job.crc;
  assign bus_rdata   = tbl_hit ? tbl_rdata : reg_rdata;
endmodule

// File: rtl/bdr_ring_seq_chk.sv
module bdr_ring_seq_chk #(
  parameter int DESC_MAX = 128,
  parameter int CNT_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             rx_en,
  input logic [CNT_W-1:0] split_q,
  input logic [CNT_W-1:0] tx_ptr,
  input logic [CNT_W-1:0] rx_ptr,
  input logic [31:0]      rx_stat,
  input logic [6:0]       irq_src,
  input logic             tx_req_valid,
  input logic             tx_req_ready,
  input logic [31:0]      tx_req_addr,
  input logic [15:0]      tx_req_len,
  input logic             tx_done_ready,
  input logic             rx_frm_valid,
  input logic             rx_frm_ready
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(DESC_MAX);

  logic rx_slot_free;
  assign rx_slot_free = rx_stat[15] && (split_q < TOP);

  assert_tx_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (tx_ptr < split_q) || (tx_ptr == '0));

  assert_rx_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> (rx_ptr >= split_q) && ((rx_ptr < TOP) || (rx_ptr == split_q)));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_valid && !tx_req_ready) |=>
      (!tx_en || (tx_req_valid && $stable(tx_req_addr) && $stable(tx_req_len))));

  assert_busy_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frm_valid && rx_frm_ready && !rx_slot_free) |=> irq_src[4]);

  assert_tx_ptr_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |=> (tx_ptr == '0));

  assert_tx_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_req_valid, tx_done_ready}));
endmodule

bind bdr_ring_seq bdr_ring_seq_chk #(.DESC_MAX(DESC_MAX), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .split_q(split_q),
  .tx_ptr(tx_ptr), .rx_ptr(rx_ptr), .rx_stat(rx_stat), .irq_src(irq_src),
  .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready),
  .tx_req_addr(tx_req_addr), .tx_req_len(tx_req_len),
  .tx_done_ready(tx_done_ready), .rx_frm_valid(rx_frm_valid),
  .rx_frm_ready(rx_frm_ready)
);

// File: tb/bdr_ring_seq_tb_top.sv
module bdr_ring_seq_tb_top;
  localparam int NDESC = 8;
  localparam logic [31:0] OWN = 32'h8000, IRQ = 32'h4000, WRAP = 32'h2000;
  localparam logic [31:0] PAD = 32'h1000, CRC = 32'h0800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        tx_req_valid, tx_req_pad, tx_req_crc, tx_done_ready, rx_frm_ready;
  logic        tx_req_ready = 1'b0, tx_done_valid = 1'b0, rx_frm_valid = 1'b0;
  logic [31:0] tx_req_addr, rx_buf_addr;
  logic [15:0] tx_req_len;
  logic [8:0]  tx_done_status = '0, rx_frm_status = '0;
  logic [15:0] rx_frm_len = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bdr_ring_seq #(.DESC_MAX(NDESC), .BUS_AW(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready),
    .tx_req_addr(tx_req_addr), .tx_req_len(tx_req_len), .tx_req_pad(tx_req_pad),
    .tx_req_crc(tx_req_crc), .tx_done_valid(tx_done_valid),
    .tx_done_ready(tx_done_ready), .tx_done_status(tx_done_status),
    .rx_frm_valid(rx_frm_valid), .rx_frm_ready(rx_frm_ready),
    .rx_frm_len(rx_frm_len), .rx_frm_status(rx_frm_status),
    .rx_buf_addr(rx_buf_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [11:0] sa(input int i);
    return 12'(12'h400 + i * 8);
  endfunction

  function automatic logic [8:0] txres(input int n, input int k);
    return 9'((n * 7 + k * 53) & 511);
  endfunction

  task automatic tx_serve(input string tag, input logic [31:0] ea, input logic [15:0] el,
                          input logic ep, input logic ec, input logic [8:0] res);
    int n = 0;
    @(negedge clk);
    while (!tx_req_valid && n < 200) begin @(negedge clk); n++; end
    chk({tag, " valid"}, 32'(tx_req_valid), 32'd1);
    chk({tag, " addr"}, tx_req_addr, ea);
    chk({tag, " len"}, 32'(tx_req_len), 32'(el));
    chk({tag, " pad/crc"}, {30'd0, tx_req_pad, tx_req_crc}, {30'd0, ep, ec});
    tx_req_ready = 1'b1;
    @(negedge clk);
    tx_req_ready = 1'b0;
    chk({tag, " done_ready"}, 32'(tx_done_ready), 32'd1);
    tx_done_valid = 1'b1; tx_done_status = res;
    @(negedge clk);
    tx_done_valid = 1'b0;
  endtask

  task automatic rx_send(input logic [15:0] len, input logic [8:0] res);
    @(negedge clk);
    rx_frm_valid = 1'b1; rx_frm_len = len; rx_frm_status = res;
    @(negedge clk);
    rx_frm_valid = 1'b0;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, exp_src, st;
    logic [31:0] exp_stat [NDESC];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, d); chk("R1 ctrl", d, 0);
    rd(12'h004, d); chk("R1 isrc", d, 0);
    rd(12'h008, d); chk("R1 imsk", d, 0);
    rd(12'h010, d); chk("R1 split", d, NDESC / 2);
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 tx_req_valid", 32'(tx_req_valid), 0);

    // R2 split saturation
    wr(12'h010, 200); rd(12'h010, d); chk("R2 sat 200", d, NDESC);
    wr(12'h010, NDESC + 1); rd(12'h010, d); chk("R2 sat max+1", d, NDESC);
    wr(12'h010, NDESC); rd(12'h010, d); chk("R2 max", d, NDESC);
    wr(12'h010, 3); rd(12'h010, d); chk("R2 small", d, 3);

    // R3 table layout
    for (int i = 0; i < NDESC; i++) begin
      wr(sa(i), 32'h5A00_0000 ^ 32'(i << 8));
      wr(sa(i) + 12'd4, 32'hC300_0001 ^ 32'(i << 12));
    end
    for (int i = 0; i < NDESC; i++) begin
      rd(sa(i), d); chk("R3 stat word", d, 32'h5A00_0000 ^ 32'(i << 8));
      rd(sa(i) + 12'd4, d); chk("R3 addr word", d, 32'hC300_0001 ^ 32'(i << 12));
    end

    // R4 R5 R6 R7 transmit sweep over ring sizes
    for (int n = 1; n <= 4; n++) begin
      wr(12'h000, 0);
      wr(12'h010, n);
      for (int i = 0; i < NDESC; i++) begin
        st = i < n ? ({16'(60 + n * 10 + i), 16'h0} | OWN | IRQ |
                      (i == n - 1 ? WRAP : 0) | ((i % 2) != 0 ? PAD : CRC))
                   : (OWN | 32'h00FF_0000);
        exp_stat[i] = st;
        wr(sa(i), st);
        wr(sa(i) + 12'd4, i < n ? 32'(32'h1000 + n * 256 + i * 16) : 32'hDEAD_0000);
      end
      wr(12'h000, 2);
      exp_src = 0;
      for (int k = 0; k < n; k++) begin
        tx_serve("R4 tx offer", 32'(32'h1000 + n * 256 + k * 16), 16'(60 + n * 10 + k),
                 (k % 2) != 0, (k % 2) == 0, txres(n, k));
        if ((txres(n, k) & 9'h10D) != 0) exp_src[1] = 1'b1; else exp_src[0] = 1'b1;
      end
      repeat (8) @(negedge clk);
      chk("R5 stall after ring", 32'(tx_req_valid), 0);
      for (int k = 0; k < n; k++) begin
        rd(sa(k), d);
        chk("R6 writeback", d, (exp_stat[k] & ~32'h81FF) | 32'(txres(n, k)));
      end
      rd(12'h004, d); chk("R6 irq bits", d, exp_src);
      wr(12'h004, 32'h7F); rd(12'h004, d); chk("R11 w1c", d, 0);
      wr(sa(0), exp_stat[0]);
      tx_serve("R7 tx wrap to 0", 32'(32'h1000 + n * 256), 16'(60 + n * 10), 1'b0, 1'b1, 9'h000);
      rd(12'h004, d); chk("R6 clean frame irq", d, 32'h1);
      wr(12'h004, 32'h7F);
    end

    // R5 no skip past a not-ready descriptor
    wr(12'h000, 0);
    wr(12'h010, 3);
    wr(sa(0), 32'h0040_0000 | WRAP);
    wr(sa(1), 32'h0041_0000 | OWN);
    wr(sa(0) + 12'd4, 32'hA0); wr(sa(1) + 12'd4, 32'hA1);
    wr(12'h000, 2);
    repeat (10) @(negedge clk);
    chk("R5 no skip", 32'(tx_req_valid), 0);
    wr(sa(0), 32'h0040_0000 | OWN);
    tx_serve("R5 head first", 32'hA0, 16'h40, 1'b0, 1'b0, 9'h0);
    tx_serve("R5 then next", 32'hA1, 16'h41, 1'b0, 1'b0, 9'h0);

    // R12 back-pressure and R10 pointer reset on disable
    wr(12'h000, 0);
    wr(12'h010, 4);
    for (int i = 0; i < 4; i++) begin
      wr(sa(i), {16'(i + 1), 16'h0} | OWN | (i == 3 ? WRAP : 0));
      wr(sa(i) + 12'd4, 32'(32'hB0 + i));
    end
    wr(12'h000, 2);
    repeat (4) @(negedge clk);
    for (int t = 0; t < 5; t++) begin
      chk("R12 held valid", 32'(tx_req_valid), 1);
      chk("R12 held addr", tx_req_addr, 32'hB0);
      @(negedge clk);
    end
    tx_serve("R12 accept", 32'hB0, 16'h1, 1'b0, 1'b0, 9'h0);
    tx_serve("R10 second", 32'hB1, 16'h2, 1'b0, 1'b0, 9'h0);
    wr(12'h000, 0);
    repeat (3) @(negedge clk);
    chk("R10 tx off no req", 32'(tx_req_valid), 0);
    wr(sa(0), 32'h0001_0000 | OWN);
    wr(12'h000, 2);
    tx_serve("R10 restart at 0", 32'hB0, 16'h1, 1'b0, 1'b0, 9'h0);
    wr(12'h000, 0);
    wr(12'h004, 32'h7F);

    // R8 R9 R7 receive sweep
    for (int s = 0; s < 3; s++) begin
      int n = s == 0 ? 2 : (s == 1 ? 4 : 7);
      wr(12'h000, 0);
      wr(12'h010, n);
      for (int i = n; i < NDESC; i++) begin
        wr(sa(i), OWN | IRQ | (i == NDESC - 1 ? WRAP : 0));
        wr(sa(i) + 12'd4, 32'(32'h8000 + i * 32));
      end
      wr(12'h000, 1);
      exp_src = 0;
      for (int k = 0; k < NDESC - n; k++) begin
        logic [8:0] res;
        res = (k % 3) == 0 ? 9'h000 : ((k % 3) == 1 ? 9'h004 : 9'h100);
        @(negedge clk);
        chk("R8 buf addr", rx_buf_addr, 32'(32'h8000 + (n + k) * 32));
        chk("R10 rx ready", 32'(rx_frm_ready), 1);
        rx_send(16'(100 + k), res);
        exp_stat[n + k] = {16'(100 + k), 16'h0} | IRQ |
                          (n + k == NDESC - 1 ? WRAP : 0) | 32'(res);
        rd(sa(n + k), d); chk("R8 rx writeback", d, exp_stat[n + k]);
        if (res == 9'h100) exp_src[6] = 1'b1;
        else if (res != 0) exp_src[3] = 1'b1;
        else exp_src[2] = 1'b1;
      end
      @(negedge clk);
      chk("R7 rx wrap to N", rx_buf_addr, 32'(32'h8000 + n * 32));
      rx_send(16'd999, 9'h0);
      rd(sa(n), d); chk("R9 drop keeps desc", d, exp_stat[n]);
      @(negedge clk);
      chk("R9 ptr stays", rx_buf_addr, 32'(32'h8000 + n * 32));
      exp_src[4] = 1'b1;
      rd(12'h004, d); chk("R8 R9 irq bits", d, exp_src);
      wr(12'h004, 32'h7F);
      wr(sa(n), OWN | IRQ);
      rx_send(16'd77, 9'h0);
      rd(sa(n), d); chk("R7 rx reuse after wrap", d, {16'd77, 16'h0} | IRQ);
    end

    // R9 no receive ring, R10 receive gating, R11 mask
    wr(12'h000, 0);
    wr(12'h010, NDESC);
    wr(12'h004, 32'h7F);
    wr(12'h000, 1);
    rx_send(16'd50, 9'h0);
    rd(12'h004, d); chk("R9 no ring busy", d, 32'h10);
    chk("R11 masked off", 32'(irq_o), 0);
    wr(12'h008, 32'h10);
    @(negedge clk); chk("R11 mask on", 32'(irq_o), 1);
    wr(12'h008, 32'h01);
    @(negedge clk); chk("R11 other mask", 32'(irq_o), 0);
    wr(12'h008, 32'h10);
    wr(12'h004, 32'h10);
    @(negedge clk); chk("R11 cleared", 32'(irq_o), 0);
    wr(12'h000, 0);
    @(negedge clk); chk("R10 rx off not ready", 32'(rx_frm_ready), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule